// File: doc/BRIEF.md
# Dual Register-File SIMD Data Mover

This block moves data between a 64-bit memory data bus and two identical register files, lane X and lane Y. Each file holds sixteen 40-bit registers. A single request names a direction (load or store), a transfer mode, a register index and whether SIMD is on. With SIMD off, only lane X takes part. With SIMD on, lane Y repeats the transfer on its own registers at the same index.

Loads come in three forms. A broadcast places the low 32-bit word in both lanes. A split sends the low word to lane X and the high word to lane Y. A double-word move fills an even/odd register pair in one file. Every 32-bit word sits in the upper 32 bits of its 40-bit register, and the low 8 bits are cleared.

Stores read the files combinationally and rebuild a 64-bit write word in the same cycle as the request. Writes commit on the next rising clock edge.

Top module: `simd_mover`

## Requirements
- R1: After reset, every register of both files holds zero, so any word store returns 64'h0.
- R2: A loaded 32-bit word goes into bits 39:8 of the target register, and bits 7:0 are cleared. A later store returns exactly the 32 bits that were loaded.
- R3: With simd_en low, a load writes only lane X. Lane Y registers keep their values.
- R4: Broadcast load (xfer_mode 0) writes mem_rdata[31:0] to X[n]. With simd_en high, it also writes the same word to Y[n].
- R5: Split load (xfer_mode 1) writes mem_rdata[31:0] to X[n]. With simd_en high, it writes mem_rdata[63:32] to Y[n].
- R6: Double load (xfer_mode 2) with even n writes mem_rdata[31:0] to X[n] and mem_rdata[63:32] to X[n+1]. With simd_en high, Y[n] and Y[n+1] receive the same two words.
- R7: xfer_err is high in the request cycle for xfer_mode 3, or for xfer_mode 2 with odd n. Such a request writes no register, and its store word is 64'h0.
- R8: A word store (xfer_mode 0 or 1) drives mem_wdata = {Y[n] word or 32'h0 when simd_en is low, X[n] word} in the request cycle.
- R9: A double store (xfer_mode 2, even n) drives mem_wdata = {X[n+1] word, X[n] word}, whatever the value of simd_en.
- R10: A load takes effect at the clock edge that ends its request cycle. mem_wdata is 64'h0 whenever no store is requested, and mem_rdata has no effect on stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request this cycle |
| req_store | input | 1 | 1 = store (files to memory), 0 = load |
| simd_en | input | 1 | SIMD mode: lane Y repeats the transfer |
| xfer_mode | input | 2 | 0 broadcast/word, 1 split/word, 2 double, 3 reserved |
| reg_idx | input | 4 | Register index n |
| mem_rdata | input | 64 | Memory read word for loads |
| mem_wdata | output | 64 | Rebuilt write word for stores |
| xfer_err | output | 1 | Illegal mode or odd double-word index |

## Verification
Two kinds of event can fall in one cycle. The first is a double load in SIMD mode, which drives four write ports across both files on the same edge. The second is a pair of back-to-back requests, where a store reads registers written by the load that ended on the edge before it.

The bench sweeps every mode, index and SIMD setting. After each load it reads the whole of both files back through SIMD word stores. It compares every word against a shadow model and checks that no neighbouring register or unused lane changed.

// File: rtl/simd_mover_pkg.sv
package simd_mover_pkg;
  typedef enum logic [1:0] {
    XM_BCAST  = 2'd0,
    XM_SPLIT  = 2'd1,
    XM_DOUBLE = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;

  localparam int unsigned NLANES = 2;
  localparam int unsigned LANE_X = 0;
  localparam int unsigned LANE_Y = 1;
endpackage

// File: rtl/simd_regfile.sv
module simd_regfile #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned REG_W = 40,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_a,
  input  logic [IDX_W-1:0] wr_idx_a,
  input  logic [REG_W-1:0] wr_data_a,
  input  logic             wr_en_b,
  input  logic [IDX_W-1:0] wr_idx_b,
  input  logic [REG_W-1:0] wr_data_b,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [REG_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [REG_W-1:0] rd_data_b
);
  logic [REG_W-1:0] regs_q [NREGS];
  logic [REG_W-1:0] regs_d [NREGS];
  logic [NREGS-1:0] reg_ce;

  always_comb begin
    for (int i = 0; i < NREGS; i++) begin
      reg_ce[i] = 1'b0;
      regs_d[i] = regs_q[i];
      if (wr_en_a && (wr_idx_a == IDX_W'(i))) begin
        reg_ce[i] = 1'b1;
        regs_d[i] = wr_data_a;
      end else if (wr_en_b && (wr_idx_b == IDX_W'(i))) begin
        reg_ce[i] = 1'b1;
        regs_d[i] = wr_data_b;
      end
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[g] <= '0;
      else if (reg_ce[g]) regs_q[g] <= regs_d[g];
    end
  end

  assign rd_data_a = regs_q[rd_idx_a];
  assign rd_data_b = regs_q[rd_idx_b];

  // R6: the two write ports of one file never target the same register
  assert_no_port_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_a && wr_en_b && (wr_idx_a == wr_idx_b)));

  // R10: a port-A write is visible on the following cycle
  assert_write_commits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_a |=> (regs_q[$past(wr_idx_a)] == $past(wr_data_a)));
endmodule

// File: rtl/simd_route.sv
module simd_route
  import simd_mover_pkg::*;
#(
  parameter int unsigned REG_W  = 40,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned MEM_W = 2 * WORD_W,
  localparam int unsigned PAD_W = REG_W - WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             simd_en,
  input  xfer_mode_e       mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [MEM_W-1:0] rdata,
  input  logic [REG_W-1:0] x_rd_lo,
  input  logic [REG_W-1:0] x_rd_hi,
  input  logic [REG_W-1:0] y_rd_lo,
  output logic [NLANES-1:0] we_lo,
  output logic [NLANES-1:0] we_hi,
  output logic [REG_W-1:0] wd_lo [NLANES],
  output logic [REG_W-1:0] wd_hi [NLANES],
  output logic [MEM_W-1:0] wdata,
  output logic             err
);
  logic [REG_W-1:0]  word_lo, word_hi;
  logic              bad, do_load, do_store;
  logic [WORD_W-1:0] xw_lo, xw_hi, yw_lo;

  assign word_lo = {rdata[WORD_W-1:0], {PAD_W{1'b0}}};
  assign word_hi = {rdata[MEM_W-1:WORD_W], {PAD_W{1'b0}}};
  assign xw_lo   = x_rd_lo[REG_W-1:PAD_W];
  assign xw_hi   = x_rd_hi[REG_W-1:PAD_W];
  assign yw_lo   = y_rd_lo[REG_W-1:PAD_W];

  always_comb begin
    bad      = (mode == XM_RSVD) || ((mode == XM_DOUBLE) && idx[0]);
    err      = req_valid && bad;
    do_load  = req_valid && !req_store && !bad;
    do_store = req_valid && req_store && !bad;
    we_lo    = '0;
    we_hi    = '0;
    wd_lo[LANE_X] = word_lo;
    wd_hi[LANE_X] = word_hi;
    wd_lo[LANE_Y] = (mode == XM_SPLIT) ? word_hi : word_lo;
    wd_hi[LANE_Y] = word_hi;
    wdata    = '0;
    if (do_load) begin
      we_lo[LANE_X] = 1'b1;
      we_lo[LANE_Y] = simd_en;
      if (mode == XM_DOUBLE) begin
        we_hi[LANE_X] = 1'b1;
        we_hi[LANE_Y] = simd_en;
      end
    end
    if (do_store) begin
      if (mode == XM_DOUBLE) wdata = {xw_hi, xw_lo};
      else                   wdata = {simd_en ? yw_lo : {WORD_W{1'b0}}, xw_lo};
    end
  end

  // R7: a rejected request writes nothing
  assert_err_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (we_lo == '0) && (we_hi == '0));

  // R3: single-data mode never writes lane Y
  assert_single_no_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !simd_en |-> !we_lo[LANE_Y] && !we_hi[LANE_Y]);

  // R10: store word quiet unless a store is requested
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_store) |-> (wdata == '0));
endmodule

// File: rtl/simd_mover.sv
module simd_mover
  import simd_mover_pkg::*;
#(
  parameter int unsigned NREGS  = 16,
  parameter int unsigned REG_W  = 40,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned MEM_W = 2 * WORD_W,
  localparam int unsigned PAD_W = REG_W - WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             simd_en,
  input  logic [1:0]       xfer_mode,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [MEM_W-1:0] mem_rdata,
  output logic [MEM_W-1:0] mem_wdata,
  output logic             xfer_err
);
  logic [NLANES-1:0] we_lo, we_hi;
  logic [REG_W-1:0]  wd_lo [NLANES];
  logic [REG_W-1:0]  wd_hi [NLANES];
  logic [REG_W-1:0]  rd_lo [NLANES];
  logic [REG_W-1:0]  rd_hi [NLANES];
  logic [IDX_W-1:0]  idx_pair;

  assign idx_pair = reg_idx | IDX_W'(1);

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    simd_regfile #(.NREGS(NREGS), .REG_W(REG_W)) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_a  (we_lo[l]),
      .wr_idx_a (reg_idx),
      .wr_data_a(wd_lo[l]),
      .wr_en_b  (we_hi[l]),
      .wr_idx_b (idx_pair),
      .wr_data_b(wd_hi[l]),
      .rd_idx_a (reg_idx),
      .rd_data_a(rd_lo[l]),
      .rd_idx_b (idx_pair),
      .rd_data_b(rd_hi[l])
    );
  end

  simd_route #(.REG_W(REG_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_store(req_store),
    .simd_en  (simd_en),
    .mode     (xfer_mode_e'(xfer_mode)),
    .idx      (reg_idx),
    .rdata    (mem_rdata),
    .x_rd_lo  (rd_lo[LANE_X]),
    .x_rd_hi  (rd_hi[LANE_X]),
    .y_rd_lo  (rd_lo[LANE_Y]),
    .we_lo    (we_lo),
    .we_hi    (we_hi),
    .wd_lo    (wd_lo),
    .wd_hi    (wd_hi),
    .wdata    (mem_wdata),
    .err      (xfer_err)
  );

  // R2: words land with the low pad bits cleared
  assert_low_pad_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo[LANE_X] |-> (wd_lo[LANE_X][PAD_W-1:0] == '0) && (wd_lo[LANE_Y][PAD_W-1:0] == '0));

  // R6: a double-word write always pairs lane X low and high ports
  assert_double_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi[LANE_X] |-> we_lo[LANE_X] && !reg_idx[0]);
endmodule

// File: tb/simd_mover_bench.sv
module simd_mover_bench;
  logic        clk, rst_n;
  logic        req_valid, req_store, simd_en;
  logic [1:0]  xfer_mode;
  logic [3:0]  reg_idx;
  logic [63:0] mem_rdata, mem_wdata;
  logic        xfer_err;

  int unsigned vectors, fails;
  bit          finished;
  logic [31:0] xm [16];
  logic [31:0] ym [16];
  logic [31:0] seed;

  simd_mover u_simd_mover (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .simd_en(simd_en), .xfer_mode(xfer_mode), .reg_idx(reg_idx),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .xfer_err(xfer_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit is_bad(input logic [1:0] m, input logic [3:0] i);
    return (m == 2'd3) || (m == 2'd2 && i[0]);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic next_data(output logic [63:0] d);
    seed = seed * 32'd1664525 + 32'd1013904223;
    d[31:0] = seed;
    seed = seed * 32'd1664525 + 32'd1013904223;
    d[63:32] = seed;
  endtask

  // load request; checks err (R7) and quiet store bus (R10) in the request cycle
  task automatic do_load(input bit s, input logic [1:0] m, input logic [3:0] i, input logic [63:0] d);
    bit bad;
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; simd_en = s;
    xfer_mode = m; reg_idx = i; mem_rdata = d;
    #1;
    bad = is_bad(m, i);
    check("R7 load err", {63'd0, xfer_err}, {63'd0, bad});
    check("R10 wdata idle on load", mem_wdata, 64'd0);
    if (!bad) begin
      xm[i] = d[31:0];
      if (s) ym[i] = (m == 2'd1) ? d[63:32] : d[31:0];
      if (m == 2'd2) begin
        xm[i+1] = d[63:32];
        if (s) ym[i+1] = d[63:32];
      end
    end
  endtask

  // store request with junk on mem_rdata (R10); checks rebuilt word
  task automatic do_store(input string req, input bit s, input logic [1:0] m, input logic [3:0] i);
    logic [63:0] exp;
    bit bad;
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b1; simd_en = s;
    xfer_mode = m; reg_idx = i; mem_rdata = {seed, ~seed};
    #1;
    bad = is_bad(m, i);
    if (bad)            exp = 64'd0;
    else if (m == 2'd2) exp = {xm[i+1], xm[i]};
    else                exp = {s ? ym[i] : 32'd0, xm[i]};
    check(req, mem_wdata, exp);
    check("R7 store err", {63'd0, xfer_err}, {63'd0, bad});
  endtask

  task automatic sweep_all(input string req);
    for (int k = 0; k < 16; k++) do_store(req, 1'b1, 2'd0, k[3:0]);
  endtask

  initial begin
    logic [63:0] d;
    vectors = 0; fails = 0; finished = 0; seed = 32'h1234_5678;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; simd_en = 1'b0;
    xfer_mode = 2'd0; reg_idx = 4'd0; mem_rdata = 64'd0;
    for (int k = 0; k < 16; k++) begin xm[k] = 32'd0; ym[k] = 32'd0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R10 idle wdata", mem_wdata, 64'd0);
    sweep_all("R1 reset state");
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 16; i++) begin
          next_data(d);
          do_load(s[0], m[1:0], i[3:0], d);
          // back-to-back store in the cycle after the load: R10, R4/R5/R6
          do_store(m == 2 ? "R6 double readback" : (m == 1 ? "R5 split readback" : "R4 bcast readback"),
                   s[0], m[1:0], i[3:0]);
          do_store("R9 double store", s[0], 2'd2, i[3:0]);
          do_store("R8 word store", s[0], 2'd1, i[3:0]);
          sweep_all(s == 0 ? "R3 lane Y kept" : "R2 word roundtrip");
        end
    // idle cycle with junk rdata
    @(negedge clk); req_valid = 1'b0; mem_rdata = '1;
    #1 check("R10 idle wdata", mem_wdata, 64'd0);
    sweep_all("R10 no write when idle");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule